// File: doc/BRIEF.md
# Retriggerable Delayed Pulse Generator

This block waits for a rising edge on a hardware trigger line and answers it with one shaped pulse. A pulse has three phases, each a whole number of timebase clock cycles: an initial delay at the resting level, an active phase at the opposite level, and a recovery phase back at the resting level. The host arms the block with a one-cycle strobe. Arming alone produces no output. The pulse sequence starts only when a trigger edge arrives after the block is armed. When the recovery phase ends, the block is armed again by itself, so every later trigger edge starts a new pulse.

The trigger line passes through a two-stage synchronizer before edge detection, which adds a fixed latency. A trigger edge that arrives while a pulse is running is dropped and not queued, and a sticky flag records the loss. A gated output gives the active phase ANDed with the synchronized trigger level. It can act as a pulse-width qualifier: it goes high only if the trigger is still high once the delay has run out. The pulse output of one instance can drive the trigger input of a second instance, so that one generator starts another. The skew between the two is then the second instance's delay plus the synchronizer latency.

Top module: `trig_pulse_gen`

## Requirements
- R1: While `rst` is high, at each clock edge `busy`, `gated_out` and `missed_edge` clear and `pulse_out` takes the value of `idle_level`. After reset the block is unarmed.
- R2: While unarmed, rising edges on `trig_in` start nothing: `busy` stays 0 and `pulse_out` stays at `idle_level`.
- R3: Take clock edge 0 as the first edge that samples `trig_in` high after it was low. If the block is armed, `busy` goes to 1 after edge 2, which is the synchronizer latency. `pulse_out` goes to the active level (the inverse of `idle_level`) after edge 2+De.
- R4: The effective delay De equals `delay_ticks`, but never less than 2. Programmed values 0, 1 and 2 all give De = 2.
- R5: The active level holds for He = max(`high_ticks`,1) cycles. The resting level then holds for Le = max(`low_ticks`,1) cycles. `busy` stays 1 from after edge 2 through the edge 2+De+He+Le-1 and falls at the next edge.
- R6: After a pulse completes, the block is armed again without a new `arm` strobe, and the next rising trigger edge starts a new pulse.
- R7: A rising trigger edge that is detected while `busy` is 1 does not start or extend a pulse. Such an edge sets `missed_edge`, which stays set until `rst` or `disarm`.
- R8: After clock edge k, `gated_out` is 1 only when `pulse_out` is at its active level after edge k and `trig_in` was sampled high at edge k-2.
- R9: When `disarm` is high at a clock edge, that edge forces `busy` and `missed_edge` to 0 and `pulse_out` to `idle_level`, and leaves the block unarmed. `disarm` takes priority over `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle strobe that arms the block when it is unarmed |
| disarm | input | 1 | Returns the block to the unarmed state |
| trig_in | input | 1 | Asynchronous start trigger, rising edge active |
| delay_ticks | input | CNT_W | Initial delay in ticks (minimum 2 applied) |
| high_ticks | input | CNT_W | Active-phase length in ticks (0 treated as 1) |
| low_ticks | input | CNT_W | Recovery-phase length in ticks (0 treated as 1) |
| idle_level | input | 1 | Resting level of `pulse_out` |
| pulse_out | output | 1 | Registered pulse output |
| gated_out | output | 1 | Active phase ANDed with the synchronized trigger |
| busy | output | 1 | High during the delay, active and recovery phases |
| missed_edge | output | 1 | Sticky: a trigger edge arrived while busy |

## Verification
A wrong phase counter shows up at the pulse edges right away. Each phase count can be read at the ports: the cycle where `busy` rises, the cycle where `pulse_out` turns active, and the cycle where `busy` falls. A one-tick error at any of these is caught in the same pulse. A wrong state after a pulse, either failing to re-arm or re-arming while still unarmed, appears as a missing or unexpected `busy` rise two cycles after the next trigger edge. The sweep covers small delay, high and low settings under both idle levels, including the clamped values. Directed cases cover unarmed triggers, triggers dropped during a pulse, short triggers that must not pass the gate, and disarm partway through a pulse.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_ARMED = 3'd1,
    ST_DELAY = 3'd2,
    ST_HIGH  = 3'd3,
    ST_LOW   = 3'd4
  } tpg_state_e;

  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/tpg_trig_sync.sv
module tpg_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_in,
  output logic trig_lvl,
  output logic trig_rise
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= trig_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[gi] <= 1'b0;
          else     chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign trig_lvl  = chain_q[STAGES-1];
  assign trig_rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tpg_phase_fsm.sv
module tpg_phase_fsm
  import tpg_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned MIN_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             disarm,
  input  logic             rise,
  input  logic [CNT_W-1:0] delay_ticks,
  input  logic [CNT_W-1:0] high_ticks,
  input  logic [CNT_W-1:0] low_ticks,
  output tpg_state_e       st_q,
  output tpg_state_e       st_d,
  output logic             missed_q
);
  localparam logic [CNT_W-1:0] DLY_FLOOR = CNT_W'(MIN_DELAY);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             in_run;

  function automatic logic [CNT_W-1:0] first_count(input logic [CNT_W-1:0] v,
                                                   input logic [CNT_W-1:0] lo);
    return ((v < lo) ? lo : v) - ONE;
  endfunction

  assign in_run = (st_q == ST_DELAY) || (st_q == ST_HIGH) || (st_q == ST_LOW);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_OFF:   if (arm) st_d = ST_ARMED;
      ST_ARMED: if (rise) begin
        st_d  = ST_DELAY;
        cnt_d = first_count(delay_ticks, DLY_FLOOR);
      end
      ST_DELAY: if (cnt_q == '0) begin
        st_d  = ST_HIGH;
        cnt_d = first_count(high_ticks, ONE);
      end else cnt_d = cnt_q - ONE;
      ST_HIGH: if (cnt_q == '0) begin
        st_d  = ST_LOW;
        cnt_d = first_count(low_ticks, ONE);
      end else cnt_d = cnt_q - ONE;
      ST_LOW: if (cnt_q == '0) st_d = ST_ARMED;
              else cnt_d = cnt_q - ONE;
      default: st_d = ST_OFF;
    endcase
    if (disarm) begin
      st_d  = ST_OFF;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_OFF;
      cnt_q    <= '0;
      missed_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (disarm)              missed_q <= 1'b0;
      else if (rise && in_run) missed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen
  import tpg_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             disarm,
  input  logic             trig_in,
  input  logic [CNT_W-1:0] delay_ticks,
  input  logic [CNT_W-1:0] high_ticks,
  input  logic [CNT_W-1:0] low_ticks,
  input  logic             idle_level,
  output logic             pulse_out,
  output logic             gated_out,
  output logic             busy,
  output logic             missed_edge
);
  logic       trig_lvl, trig_rise;
  tpg_state_e st_q, st_d;
  logic       active_d, busy_d;

  tpg_trig_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .trig_in  (trig_in),
    .trig_lvl (trig_lvl),
    .trig_rise(trig_rise)
  );

  tpg_phase_fsm #(.CNT_W(CNT_W), .MIN_DELAY(2)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .disarm     (disarm),
    .rise       (trig_rise),
    .delay_ticks(delay_ticks),
    .high_ticks (high_ticks),
    .low_ticks  (low_ticks),
    .st_q       (st_q),
    .st_d       (st_d),
    .missed_q   (missed_edge)
  );

  assign active_d = (st_d == ST_HIGH);
  assign busy_d   = (st_d == ST_DELAY) || (st_d == ST_HIGH) || (st_d == ST_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_out <= idle_level;
      gated_out <= 1'b0;
      busy      <= 1'b0;
    end else begin
      pulse_out <= active_d ? ~idle_level : idle_level;
      gated_out <= active_d & trig_lvl;
      busy      <= busy_d;
    end
  end
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
  import tpg_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       disarm,
  input logic       idle_level,
  input logic       pulse_out,
  input logic       gated_out,
  input logic       busy,
  input logic       missed_edge,
  input tpg_state_e st_q
);
  // R9: disarm empties the block at the next edge
  a_r9_disarm_idle: assert property (@(posedge clk) disable iff (rst)
    disarm |=> (!busy && !missed_edge && pulse_out == $past(idle_level)));

  // R5: active level only appears inside a busy pulse
  a_r5_active_in_busy: assert property (@(posedge clk) disable iff (rst)
    (pulse_out != $past(idle_level)) |-> busy);

  // R8: gated output never asserted outside a pulse
  a_r8_gated_in_busy: assert property (@(posedge clk) disable iff (rst)
    gated_out |-> busy);

  // R7: missed flag is sticky until disarm
  a_r7_missed_sticky: assert property (@(posedge clk) disable iff (rst)
    (missed_edge && !disarm) |=> missed_edge);

  // R2: a pulse can only begin from the armed state
  a_r2_start_from_armed: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(st_q) == ST_ARMED));

  // R4: at least two delay cycles at rest after the pulse starts
  a_r4_min_delay: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !disarm) |=> (busy && pulse_out == $past(idle_level)));
endmodule

bind trig_pulse_gen tpg_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .disarm     (disarm),
  .idle_level (idle_level),
  .pulse_out  (pulse_out),
  .gated_out  (gated_out),
  .busy       (busy),
  .missed_edge(missed_edge),
  .st_q       (st_q)
);

// File: tb/trig_pulse_gen_bench.sv
module trig_pulse_gen_bench;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst, arm, disarm, trig_in, idle_level;
  logic [CW-1:0] delay_ticks, high_ticks, low_ticks;
  logic          pulse_out, gated_out, busy, missed_edge;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  trig_pulse_gen #(.CNT_W(CW)) u_trig_pulse_gen (
    .clk(clk), .rst(rst), .arm(arm), .disarm(disarm), .trig_in(trig_in),
    .delay_ticks(delay_ticks), .high_ticks(high_ticks), .low_ticks(low_ticks),
    .idle_level(idle_level), .pulse_out(pulse_out), .gated_out(gated_out),
    .busy(busy), .missed_edge(missed_edge)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // Sweep one configuration; trigger held high through the whole window.
  task automatic run_cfg(input int d, input int h, input int l, input logic idl);
    int de, he, le, span;
    de = (d < 2) ? 2 : d;
    he = (h < 1) ? 1 : h;
    le = (l < 1) ? 1 : l;
    span = 2 + de + he + le;
    delay_ticks = CW'(d); high_ticks = CW'(h); low_ticks = CW'(l);
    idle_level = idl;
    settle(2);
    trig_in = 1'b1;
    for (int k = 0; k < span + 3; k++) begin
      logic act_exp;
      step();
      act_exp = (k >= 2 + de) && (k < 2 + de + he);
      chk(pulse_out, act_exp ? ~idl : idl, "R3/R4 pulse level");
      chk(busy, (k >= 2) && (k < span), "R5 busy window");
      chk(gated_out, act_exp, "R8 gated with long trigger");
    end
    trig_in = 1'b0;
    settle(4);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; arm = 1'b0; disarm = 1'b0; trig_in = 1'b0; idle_level = 1'b0;
    delay_ticks = '0; high_ticks = '0; low_ticks = '0;
    @(negedge clk);
    settle(3);
    // R1 reset values
    chk(pulse_out, 1'b0, "R1 pulse in reset");
    chk(busy, 1'b0, "R1 busy in reset");
    chk(gated_out, 1'b0, "R1 gated in reset");
    chk(missed_edge, 1'b0, "R1 missed in reset");
    rst = 1'b0;
    delay_ticks = CW'(3); high_ticks = CW'(2); low_ticks = CW'(2);
    settle(2);

    // R2 unarmed: trigger does nothing
    trig_in = 1'b1;
    for (int k = 0; k < 12; k++) begin
      step();
      chk(busy, 1'b0, "R2 busy while unarmed");
      chk(pulse_out, 1'b0, "R2 pulse while unarmed");
    end
    trig_in = 1'b0;
    settle(4);

    arm = 1'b1; step(); arm = 1'b0;

    // R3 R4 R5 R6 R8: sweep, re-arm is automatic between configs
    for (int idl = 0; idl < 2; idl++)
      for (int d = 0; d < 6; d++)
        for (int h = 0; h < 4; h++)
          for (int l = 0; l < 3; l++)
            run_cfg(d, h, l, idl[0]);
    idle_level = 1'b0;

    // R8: short trigger, pulse happens, gate stays low
    delay_ticks = CW'(5); high_ticks = CW'(3); low_ticks = CW'(1);
    settle(2);
    trig_in = 1'b1;
    for (int k = 0; k < 14; k++) begin
      step();
      if (k == 1) trig_in = 1'b0;
      chk(pulse_out, (k >= 7) && (k < 10), "R8 pulse with short trigger");
      chk(gated_out, 1'b0, "R8 gate blocks short trigger");
    end
    settle(4);

    // R7: second edge during the pulse is dropped and flagged
    delay_ticks = CW'(4); high_ticks = CW'(2); low_ticks = CW'(2);
    settle(2);
    chk(missed_edge, 1'b0, "R7 missed clear before");
    trig_in = 1'b1;
    for (int k = 0; k < 20; k++) begin
      step();
      if (k == 3) trig_in = 1'b0;
      if (k == 5) trig_in = 1'b1;
      chk(pulse_out, (k >= 6) && (k < 8), "R7 single pulse only");
      chk(busy, (k >= 2) && (k < 10), "R7 busy not extended");
    end
    chk(missed_edge, 1'b1, "R7 missed flag set");
    trig_in = 1'b0;
    settle(4);
    chk(missed_edge, 1'b1, "R7 missed flag sticky");

    // R9: disarm mid-pulse
    delay_ticks = CW'(2); high_ticks = CW'(6); low_ticks = CW'(1);
    trig_in = 1'b1;
    for (int k = 0; k < 6; k++) step();
    chk(pulse_out, 1'b1, "R9 pulse active before disarm");
    disarm = 1'b1; step(); disarm = 1'b0;
    chk(pulse_out, 1'b0, "R9 pulse idle after disarm");
    chk(busy, 1'b0, "R9 busy cleared by disarm");
    chk(missed_edge, 1'b0, "R9 missed cleared by disarm");
    trig_in = 1'b0;
    settle(4);
    trig_in = 1'b1;
    for (int k = 0; k < 10; k++) begin
      step();
      chk(busy, 1'b0, "R9 unarmed after disarm");
    end
    trig_in = 1'b0;
    settle(4);

    // R9: disarm beats arm in the same cycle
    arm = 1'b1; disarm = 1'b1; step(); arm = 1'b0; disarm = 1'b0;
    trig_in = 1'b1;
    for (int k = 0; k < 10; k++) begin
      step();
      chk(busy, 1'b0, "R9 disarm priority over arm");
    end
    trig_in = 1'b0;
    settle(4);

    // R6: arm once, two pulses back to back without re-arming
    arm = 1'b1; step(); arm = 1'b0;
    for (int rep = 0; rep < 2; rep++) begin
      trig_in = 1'b1;
      for (int k = 0; k < 12; k++) begin
        step();
        chk(busy, (k >= 2) && (k < 11), "R6 retrigger busy window");
      end
      trig_in = 1'b0;
      settle(4);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule